// File: doc/BRIEF.md
# Indirect Register File Addressing Unit

This unit resolves the register-file address for an 8-bit core that reaches its data registers either directly, by the address field carried in the instruction, or indirectly, through a pointer register. One register address is reserved as a virtual indirect port. It has no storage of its own. When an instruction names that port, the access goes instead to the location held in the pointer register. That location is extended by one bank bit taken from the status register. Every other address is a direct access. A direct access combines the supplied pair of bank-select bits with the 7-bit instruction address.

The unit also handles the case where the pointer refers back to the virtual port itself. It compares the low 7 pointer bits against the port address. On a match, an indirect read is flagged so that the datapath substitutes zero, and an indirect write is blocked. The datapath may still update its flags on a blocked write. The logic is purely combinational. The register storage and the ALU sit outside the unit and consume the effective address, the gated write enable and the forced-zero read flag in the same cycle.

Top module: `irfa_unit`

## Requirements
- R1: When the instruction address is not 0x00, the 9-bit effective address is the 2-bit direct bank field in bits 8:7 above the 7-bit instruction address in bits 6:0.
- R2: When the instruction address is 0x00 (the virtual indirect port), the effective address is the indirect bank bit in bit 8 above the 8-bit pointer value in bits 7:0.
- R3: The indirect bank bit has no effect on a direct access. The direct bank field has no effect on an indirect access.
- R4: An indirect read whose pointer has low 7 bits equal to zero raises the forced-zero read flag. This holds whatever the pointer's bit 7 and the indirect bank bit are.
- R5: An indirect write whose pointer has low 7 bits equal to zero drives the write enable low.
- R6: In every other case, the write enable equals the write strobe.
- R7: The forced-zero read flag is low unless the read strobe is high and the self-reference condition of R4 holds. This includes direct accesses to the pointer register address 0x04.
- R8: Stepping the pointer through a range, such as 0x20 to 0x2F, yields one enabled write per location at the matching effective address.
- R9: All outputs follow the inputs in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_addr_i | input | 7 | Register address field of the instruction |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| ptr_i | input | 8 | Current value of the pointer register |
| ind_bank_i | input | 1 | Bank bit from the status register, used for indirect accesses |
| dir_bank_i | input | 2 | Bank-select bits used for direct accesses |
| eff_addr_o | output | 9 | Resolved register-file address |
| wr_en_o | output | 1 | Write enable after self-reference gating |
| rd_zero_o | output | 1 | Read data must be forced to 0x00 |

## Verification
The bench builds the unit with its default widths: a 7-bit instruction address, an 8-bit pointer and a 2-bit direct bank field. With these widths, pointer bit 7 lies outside the self-reference compare. As a result, 0x80 reaches the self-reference case just as 0x00 does, and both values of the indirect bank bit can be combined with it. The defaults also give the full 9-bit address, so the top direct bank and the top of a pointer sweep are both reachable.

// File: rtl/irfa_pkg.sv
package irfa_pkg;

  // Kind of access resolved from the instruction address field.
  typedef enum logic {
    ACC_DIRECT   = 1'b0,
    ACC_INDIRECT = 1'b1
  } acc_kind_e;

endpackage

// File: rtl/irfa_decode.sv
module irfa_decode
  import irfa_pkg::*;
#(
  parameter int unsigned DIR_W     = 7,
  parameter int unsigned VIRT_ADDR = 0
) (
  input  logic [DIR_W-1:0] reg_addr_i,
  output acc_kind_e        kind_o
);

  localparam logic [DIR_W-1:0] VirtAddr = DIR_W'(VIRT_ADDR);

  always_comb begin
    kind_o = ACC_DIRECT;
    if (reg_addr_i == VirtAddr) begin
      kind_o = ACC_INDIRECT;
    end
  end

endmodule

// File: rtl/irfa_selfref.sv
module irfa_selfref #(
  parameter int unsigned PTR_W     = 8,
  parameter int unsigned CMP_W     = 7,
  parameter int unsigned VIRT_ADDR = 0
) (
  input  logic [PTR_W-1:0] ptr_i,
  output logic             hit_o
);

  localparam logic [CMP_W-1:0] VirtAddr = CMP_W'(VIRT_ADDR);

  logic [CMP_W-1:0] low_bits;

  // Only the low bits take part, so every bank's copy of the port matches.
  generate
    if (CMP_W < PTR_W) begin : g_trunc
      logic [PTR_W-CMP_W-1:0] upper_unused;
      assign low_bits     = ptr_i[CMP_W-1:0];
      assign upper_unused = ptr_i[PTR_W-1:CMP_W];
    end else begin : g_full
      assign low_bits = CMP_W'(ptr_i);
    end
  endgenerate

  assign hit_o = (low_bits == VirtAddr);

endmodule

// File: rtl/irfa_addr_mux.sv
module irfa_addr_mux
  import irfa_pkg::*;
#(
  parameter int unsigned DIR_W  = 7,
  parameter int unsigned PTR_W  = 8,
  parameter int unsigned BANK_W = 2
) (
  input  acc_kind_e         kind_i,
  input  logic [DIR_W-1:0]  reg_addr_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic              ind_bank_i,
  input  logic [BANK_W-1:0] dir_bank_i,
  output logic [PTR_W:0]    eff_addr_o
);

  localparam int unsigned EFF_W = PTR_W + 1;
  localparam int unsigned CAT_W = BANK_W + DIR_W;

  logic [EFF_W-1:0] ind_addr;
  logic [EFF_W-1:0] dir_addr;
  logic [CAT_W-1:0] dir_cat;

  assign ind_addr = {ind_bank_i, ptr_i};
  assign dir_cat  = {dir_bank_i, reg_addr_i};

  // Fit the direct address into the effective width.
  generate
    if (CAT_W == EFF_W) begin : g_exact
      assign dir_addr = dir_cat;
    end else if (CAT_W < EFF_W) begin : g_pad
      assign dir_addr = {{(EFF_W-CAT_W){1'b0}}, dir_cat};
    end else begin : g_cut
      logic [CAT_W-EFF_W-1:0] cut_unused;
      assign dir_addr   = dir_cat[EFF_W-1:0];
      assign cut_unused = dir_cat[CAT_W-1:EFF_W];
    end
  endgenerate

  always_comb begin
    unique case (kind_i)
      ACC_INDIRECT: eff_addr_o = ind_addr;
      default:      eff_addr_o = dir_addr;
    endcase
  end

endmodule

// File: rtl/irfa_strobe_gate.sv
module irfa_strobe_gate
  import irfa_pkg::*;
(
  input  acc_kind_e kind_i,
  input  logic      self_hit_i,
  input  logic      rd_i,
  input  logic      wr_i,
  output logic      wr_en_o,
  output logic      rd_zero_o
);

  logic self_ref;

  always_comb begin
    self_ref  = (kind_i == ACC_INDIRECT) && self_hit_i;
    wr_en_o   = wr_i && !self_ref;
    rd_zero_o = rd_i && self_ref;
  end

endmodule

// File: rtl/irfa_unit.sv
module irfa_unit
  import irfa_pkg::*;
#(
  parameter int unsigned DIR_W     = 7,
  parameter int unsigned PTR_W     = 8,
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned VIRT_ADDR = 0
) (
  input  logic [DIR_W-1:0]  reg_addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [PTR_W-1:0]  ptr_i,
  input  logic              ind_bank_i,
  input  logic [BANK_W-1:0] dir_bank_i,
  output logic [PTR_W:0]    eff_addr_o,
  output logic              wr_en_o,
  output logic              rd_zero_o
);

  localparam int unsigned CMP_W = DIR_W;

  acc_kind_e kind;
  logic      self_hit;

  irfa_decode #(
    .DIR_W     (DIR_W),
    .VIRT_ADDR (VIRT_ADDR)
  ) u_decode (
    .reg_addr_i (reg_addr_i),
    .kind_o     (kind)
  );

  irfa_selfref #(
    .PTR_W     (PTR_W),
    .CMP_W     (CMP_W),
    .VIRT_ADDR (VIRT_ADDR)
  ) u_selfref (
    .ptr_i (ptr_i),
    .hit_o (self_hit)
  );

  irfa_addr_mux #(
    .DIR_W  (DIR_W),
    .PTR_W  (PTR_W),
    .BANK_W (BANK_W)
  ) u_mux (
    .kind_i     (kind),
    .reg_addr_i (reg_addr_i),
    .ptr_i      (ptr_i),
    .ind_bank_i (ind_bank_i),
    .dir_bank_i (dir_bank_i),
    .eff_addr_o (eff_addr_o)
  );

  irfa_strobe_gate u_gate (
    .kind_i     (kind),
    .self_hit_i (self_hit),
    .rd_i       (rd_i),
    .wr_i       (wr_i),
    .wr_en_o    (wr_en_o),
    .rd_zero_o  (rd_zero_o)
  );

endmodule

// File: rtl/irfa_unit_chk.sv
module irfa_unit_chk #(
  parameter int unsigned DIR_W     = 7,
  parameter int unsigned PTR_W     = 8,
  parameter int unsigned BANK_W    = 2,
  parameter int unsigned VIRT_ADDR = 0
) (
  input logic [DIR_W-1:0]  reg_addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [PTR_W-1:0]  ptr_i,
  input logic              ind_bank_i,
  input logic [BANK_W-1:0] dir_bank_i,
  input logic [PTR_W:0]    eff_addr_o,
  input logic              wr_en_o,
  input logic              rd_zero_o
);

  logic is_ind;
  logic is_self;

  assign is_ind  = (reg_addr_i == DIR_W'(VIRT_ADDR));
  assign is_self = is_ind && (ptr_i[DIR_W-1:0] == DIR_W'(VIRT_ADDR));

  always_comb begin
    // R1
    dir_addr_chk: assert (is_ind || eff_addr_o[DIR_W-1:0] == reg_addr_i);
    // R2
    ind_addr_chk: assert (!is_ind || eff_addr_o == {ind_bank_i, ptr_i});
    // R5
    self_wr_block_chk: assert (!(is_self && wr_en_o));
    // R6
    wr_follow_chk: assert (is_self || wr_en_o == wr_i);
    // R7
    rd_zero_cause_chk: assert (!rd_zero_o || (rd_i && is_self));
    // R4
    rd_zero_raise_chk: assert (!(rd_i && is_self) || rd_zero_o);
  end

  logic bank_unused;
  assign bank_unused = ^dir_bank_i;

endmodule

bind irfa_unit irfa_unit_chk #(
  .DIR_W     (DIR_W),
  .PTR_W     (PTR_W),
  .BANK_W    (BANK_W),
  .VIRT_ADDR (VIRT_ADDR)
) u_chk (
  .reg_addr_i (reg_addr_i),
  .rd_i       (rd_i),
  .wr_i       (wr_i),
  .ptr_i      (ptr_i),
  .ind_bank_i (ind_bank_i),
  .dir_bank_i (dir_bank_i),
  .eff_addr_o (eff_addr_o),
  .wr_en_o    (wr_en_o),
  .rd_zero_o  (rd_zero_o)
);

// File: tb/tb_irfa_unit.sv
module tb_irfa_unit;

  logic clk;
  logic [6:0] reg_addr;
  logic       rd, wr;
  logic [7:0] ptr;
  logic       ib;
  logic [1:0] db;
  logic [8:0] eff;
  logic       we, rz;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  irfa_unit dut (
    .reg_addr_i (reg_addr),
    .rd_i       (rd),
    .wr_i       (wr),
    .ptr_i      (ptr),
    .ind_bank_i (ib),
    .dir_bank_i (db),
    .eff_addr_o (eff),
    .wr_en_o    (we),
    .rd_zero_o  (rz)
  );

  // Fields: addr, rd, wr, ptr, ib, db | exp eff, exp we, exp rz
  localparam int NV = 10;
  localparam logic [30:0] VEC [NV] = '{
    {7'h05, 1'b1, 1'b0, 8'h33, 1'b1, 2'b01, 9'h085, 1'b0, 1'b0}, // R1 R3
    {7'h7F, 1'b0, 1'b1, 8'h00, 1'b0, 2'b11, 9'h1FF, 1'b1, 1'b0}, // R1 R6
    {7'h00, 1'b1, 1'b0, 8'h45, 1'b0, 2'b11, 9'h045, 1'b0, 1'b0}, // R2 R3
    {7'h00, 1'b0, 1'b1, 8'hA0, 1'b1, 2'b00, 9'h1A0, 1'b1, 1'b0}, // R2 R6
    {7'h00, 1'b1, 1'b0, 8'h00, 1'b0, 2'b10, 9'h000, 1'b0, 1'b1}, // R4
    {7'h00, 1'b0, 1'b1, 8'h80, 1'b1, 2'b01, 9'h180, 1'b0, 1'b0}, // R5
    {7'h00, 1'b1, 1'b1, 8'h80, 1'b0, 2'b00, 9'h080, 1'b0, 1'b1}, // R4 R5
    {7'h04, 1'b1, 1'b1, 8'h00, 1'b1, 2'b00, 9'h004, 1'b1, 1'b0}, // R7
    {7'h00, 1'b1, 1'b0, 8'h01, 1'b0, 2'b00, 9'h001, 1'b0, 1'b0}, // R7
    {7'h00, 1'b0, 1'b0, 8'h00, 1'b1, 2'b00, 9'h100, 1'b0, 1'b0}  // R7
  };

  task automatic drive(input logic [6:0] a, input logic r, input logic w,
                       input logic [7:0] p, input logic b, input logic [1:0] d);
    reg_addr = a; rd = r; wr = w; ptr = p; ib = b; db = d;
  endtask

  task automatic check(input string req, input logic [8:0] e_eff,
                       input logic e_we, input logic e_rz);
    checks++;
    if (eff !== e_eff || we !== e_we || rz !== e_rz) begin
      fails++;
      $display("FAIL %s: got eff=%h we=%b rz=%b, expected eff=%h we=%b rz=%b",
               req, eff, we, rz, e_eff, e_we, e_rz);
    end
  endtask

  initial begin
    drive(7'h00, 1'b0, 1'b0, 8'h00, 1'b0, 2'b00);
    @(negedge clk);
    // Reset state: idle inputs give no enable and no forced zero (R7)
    check("R7 idle", 9'h000, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [30:0] v;
      v = VEC[i];
      @(negedge clk);
      drive(v[30:24], v[23], v[22], v[21:14], v[13], v[12:11]);
      #1;
      check($sformatf("R1-table vec %0d", i), v[10:2], v[1], v[0]);
    end

    // R8: pointer sweep clearing 0x20..0x2F
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      drive(7'h00, 1'b0, 1'b1, 8'(8'h20 + k), 1'b0, 2'b11);
      #1;
      check("R8 sweep", 9'(9'h020 + k), 1'b1, 1'b0);
    end

    // R5 / R4: self-reference in every pointer/bank combination
    for (int m = 0; m < 4; m++) begin
      logic [7:0] p;
      p = m[0] ? 8'h80 : 8'h00;
      @(negedge clk);
      drive(7'h00, 1'b1, 1'b1, p, m[1], 2'b01);
      #1;
      check("R5 self write", {m[1], p}, 1'b0, 1'b1);
    end

    // R3: indirect bank bit ignored on a direct access
    @(negedge clk);
    drive(7'h10, 1'b0, 1'b1, 8'hFF, 1'b0, 2'b10);
    #1;
    check("R3 ib=0", 9'h110, 1'b1, 1'b0);
    ib = 1'b1;
    #1;
    check("R3 ib=1", 9'h110, 1'b1, 1'b0);

    // R9: outputs change without any clock edge
    @(posedge clk);
    #0.5;
    drive(7'h00, 1'b0, 1'b1, 8'h7F, 1'b1, 2'b00);
    #0.5;
    check("R9 no edge", 9'h17F, 1'b1, 1'b0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule